// File: doc/BRIEF.md
# Dual-Output PWM Timer Channel

This block is one timer channel that turns a 16-bit up-counter into two pulse-width-modulated outputs. A small write-only register port sets a control word (tick divider code and which compare register ends the period), a mode bit, a per-output drive enable, a run bit and four 16-bit compare registers. The counter advances once per prescaled tick and returns to zero after it has matched the selected period register. Each output compares the shared counter against its own pair of compare registers: the first output uses A (period) and B (duty), the second uses C (period) and D (duty).

Compare writes land in a buffer and are copied to the working registers at the next counter clear, so a period never ends with a half-updated setting. The divider code and the clear source are shared by both outputs, and the block refuses to change them while the counter runs. An output whose drive enable is off releases its pin to high impedance. The present count and the run state are visible at the ports.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset all registers are zero: the counter reads 0, the run state is 0, both pin drive enables are 0 and both levels are 0.
- R2: While running, the counter advances by one every 4^code clocks, where code is bits [1:0] of the control register (address 0); between ticks it holds its value.
- R3: Bit 2 of the control register picks the clear source: 0 selects compare A (address 4), 1 selects compare C (address 6). The counter returns to 0 on the tick after it equals that value, so a period lasts value+1 ticks.
- R4: Output 0 level, with working values A and B: low when B is 0, high when B is not less than A, otherwise high exactly while the counter is below B. Output 1 follows the same rule with C (period) and D (duty, address 7).
- R5: Bit n of the output-control register (address 2) set to 1 drives pin n with its level and sets its drive-enable port; set to 0 the pin is released to high impedance and the drive-enable port reads 0.
- R6: A write to the control register while the counter runs is ignored; the divider and clear source keep their old values.
- R7: Writing 1 to bit 0 of the run register (address 3) while stopped starts the counter from 0 with a fresh prescaler; writing 0 stops it and the count is frozen. Writing 1 while already running has no effect.
- R8: A compare write while running takes effect at the next counter clear; while stopped it takes effect on the next clock.
- R9: With mode register (address 1) bit 0 at 0, or with the counter stopped, both levels are low.
- R10: The status ports report the current count and the run state at every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 mode, 2 output control, 3 run, 4..7 compare A..D) |
| reg_wdata | input | CNT_W | Write data |
| pwm_pin | output | 2 | Tri-stateable PWM pins |
| pwm_lvl | output | 2 | Level each output would drive |
| pwm_oe | output | 2 | Drive enable of each pin |
| cnt_o | output | CNT_W | Current counter value |
| run_o | output | 1 | Counter running |

## Verification
The hardest state to reach from the ports is a compare write that arrives mid-period while the counter is past the new value: a wrong design wraps early or runs to the counter limit. A directed case starts a long period, lowers it while the count is already above the new value, and checks that the old period completes and the next one uses the new value. Random stimulus then keeps periods small and mixes compare writes, divider changes attempted while running, start/stop and mode toggles, with a cycle model in the bench compared on every clock.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int unsigned NUM_CMP = 4;
   localparam int unsigned NUM_OUT = 2;

   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_MODE   = 3'd1,
      REG_OUTCTL = 3'd2,
      REG_RUN    = 3'd3,
      REG_CMPA   = 3'd4,
      REG_CMPB   = 3'd5,
      REG_CMPC   = 3'd6,
      REG_CMPD   = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
   parameter int unsigned CODE_W = 2,
   parameter bit          PSC_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int unsigned DIV_W = 2 * ((1 << CODE_W) - 1);

   generate
      if (PSC_EN) begin : g_div
         logic [DIV_W-1:0] pcnt;
         logic [DIV_W-1:0] term;

         assign term = (DIV_W'(1) << (2 * code)) - DIV_W'(1);
         assign tick = run && (pcnt == term);

         always_ff @(posedge clk) begin
            if (!rst_n)            pcnt <= '0;
            else if (!run || tick) pcnt <= '0;
            else                   pcnt <= pcnt + DIV_W'(1);
         end
      end else begin : g_nodiv
         logic unused_code;
         assign unused_code = ^code;
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   assign wrap = tick && (cnt == period);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (start) cnt <= '0;
      else if (tick)  cnt <= wrap ? '0 : cnt + CNT_W'(1);
   end
endmodule

// File: rtl/pwmt_cmpbank.sv
module pwmt_cmpbank #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned NUM   = 4
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM-1:0]            wr,
   input  logic [CNT_W-1:0]          wdata,
   input  logic                      load,
   output logic [NUM-1:0][CNT_W-1:0] work
);
   generate
      for (genvar i = 0; i < NUM; i++) begin : g_reg
         logic [CNT_W-1:0] buf_q;

         always_ff @(posedge clk) begin
            if (!rst_n)     buf_q <= '0;
            else if (wr[i]) buf_q <= wdata;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)    work[i] <= '0;
            else if (load) work[i] <= buf_q;
         end
      end
   endgenerate
endmodule

// File: rtl/pwmt_outstage.sv
module pwmt_outstage #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             active,
   input  logic             drive_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per,
   input  logic [CNT_W-1:0] duty,
   output logic             lvl,
   output logic             oe
);
   always_comb begin
      if (!active)          lvl = 1'b0;
      else if (duty == '0)  lvl = 1'b0;
      else if (duty >= per) lvl = 1'b1;
      else                  lvl = (cnt < duty);
   end

   assign oe = drive_en;
endmodule

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CODE_W = 2,
   parameter bit          PSC_EN = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [2:0]         reg_addr,
   input  logic [CNT_W-1:0]   reg_wdata,
   output wire  [NUM_OUT-1:0] pwm_pin,
   output logic [NUM_OUT-1:0] pwm_lvl,
   output logic [NUM_OUT-1:0] pwm_oe,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               run_o
);
   localparam int unsigned CTRL_W = CODE_W + 1;

   generate
      if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code
         $error("CODE_W must lie in 1..3");
      end
      if (CNT_W < CTRL_W || CNT_W < NUM_OUT || CNT_W > 32) begin : g_bad_width
         $error("CNT_W must hold the control word and be at most 32");
      end
   endgenerate

   reg_addr_e            sel;
   logic [CTRL_W-1:0]    ctrl_q;
   logic                 mode_q;
   logic [NUM_OUT-1:0]   oc_q;
   logic                 run_q;
   logic                 start;
   logic                 tick;
   logic                 wrap;
   logic                 load;
   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     period_act;
   logic [NUM_CMP-1:0]   cmp_wr;
   logic [NUM_CMP-1:0][CNT_W-1:0] work;

   assign sel   = reg_addr_e'(reg_addr);
   assign start = reg_we && (sel == REG_RUN) && reg_wdata[0] && !run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= 1'b0;
         oc_q   <= '0;
         run_q  <= 1'b0;
      end else if (reg_we) begin
         unique case (sel)
            REG_CTRL:   if (!run_q) ctrl_q <= reg_wdata[CTRL_W-1:0];
            REG_MODE:   mode_q <= reg_wdata[0];
            REG_OUTCTL: oc_q   <= reg_wdata[NUM_OUT-1:0];
            REG_RUN:    run_q  <= reg_wdata[0];
            default:    ;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_wsel
         assign cmp_wr[i] = reg_we && (reg_addr == (3'(REG_CMPA) + 3'(i)));
      end
   endgenerate

   pwmt_prescaler #(.CODE_W(CODE_W), .PSC_EN(PSC_EN)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .code  (ctrl_q[CODE_W-1:0]),
      .tick  (tick)
   );

   assign period_act = ctrl_q[CODE_W] ? work[2] : work[0];

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .tick   (tick),
      .period (period_act),
      .cnt    (cnt_q),
      .wrap   (wrap)
   );

   assign load = !run_q || wrap;

   pwmt_cmpbank #(.CNT_W(CNT_W), .NUM(NUM_CMP)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr),
      .wdata (reg_wdata),
      .load  (load),
      .work  (work)
   );

   generate
      for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
         pwmt_outstage #(.CNT_W(CNT_W)) u_os (
            .active   (run_q && mode_q),
            .drive_en (oc_q[g]),
            .cnt      (cnt_q),
            .per      (work[2*g]),
            .duty     (work[2*g+1]),
            .lvl      (pwm_lvl[g]),
            .oe       (pwm_oe[g])
         );
         assign pwm_pin[g] = pwm_oe[g] ? pwm_lvl[g] : 1'bz;
      end
   endgenerate

   assign cnt_o = cnt_q;
   assign run_o = run_q;
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CTRL_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              run_q,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  period,
   input logic [CTRL_W-1:0] ctrl,
   input logic [1:0]        lvl
);
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> cnt <= period); // R3

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cnt == period) |=> cnt == '0); // R3

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick) |=> $stable(cnt)); // R2

   AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> cnt == '0); // R7

   AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(ctrl)); // R6

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> lvl == 2'b00); // R9
endmodule

bind pwm_timer_ch pwmt_chk #(.CNT_W(CNT_W), .CTRL_W(CODE_W + 1)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run_q  (run_q),
   .tick   (tick),
   .cnt    (cnt_q),
   .period (period_act),
   .ctrl   (ctrl_q),
   .lvl    (pwm_lvl)
);

// File: tb/sim_pwm_timer_ch.sv
module sim_pwm_timer_ch;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         we = 1'b0;
   logic [2:0]   ad = '0;
   logic [W-1:0] wd = '0;
   wire  [1:0]   pin;
   logic [1:0]   lvl, oe;
   logic [W-1:0] cnt;
   logic         run;

   pwm_timer_ch #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(ad), .reg_wdata(wd),
      .pwm_pin(pin), .pwm_lvl(lvl), .pwm_oe(oe), .cnt_o(cnt), .run_o(run)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- cycle model built from the requirements ----------------
   logic [2:0]   m_ctrl;
   logic         m_mode, m_run;
   logic [1:0]   m_oc;
   logic [W-1:0] m_cnt;
   int           m_psc;
   logic [W-1:0] m_buf [4];
   logic [W-1:0] m_sh  [4];

   function automatic int term(input logic [1:0] c);
      return (1 << (2 * c)) - 1;
   endfunction

   function automatic logic lvl_f(input logic [W-1:0] c, input logic [W-1:0] p, input logic [W-1:0] d);
      if (d == 0) return 1'b0;
      if (d >= p) return 1'b1;
      return c < d;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_mode = 0; m_run = 0; m_oc = '0; m_cnt = '0; m_psc = 0;
         for (int i = 0; i < 4; i++) begin m_buf[i] = '0; m_sh[i] = '0; end
      end else begin
         logic r, tk, wr;
         logic [W-1:0] per;
         r   = m_run;
         tk  = r && (m_psc == term(m_ctrl[1:0]));
         per = m_ctrl[2] ? m_sh[2] : m_sh[0];
         wr  = tk && (m_cnt == per);
         if (!r || tk) m_psc = 0; else m_psc++;
         if (tk) m_cnt = wr ? '0 : m_cnt + 1'b1;
         if (!r || wr) for (int i = 0; i < 4; i++) m_sh[i] = m_buf[i];
         if (we) begin
            case (ad)
               3'd0: if (!r) m_ctrl = wd[2:0];
               3'd1: m_mode = wd[0];
               3'd2: m_oc = wd[1:0];
               3'd3: begin
                  if (wd[0] && !r) m_cnt = '0;
                  m_run = wd[0];
               end
               default: m_buf[ad - 3'd4] = wd;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2/R3 count", cnt, m_cnt);
         chk("R10 run state", run, m_run);
         for (int n = 0; n < 2; n++) begin
            chk("R4/R9 level", lvl[n], m_run && m_mode && lvl_f(m_cnt, m_sh[2*n], m_sh[2*n+1]));
            chk("R5 drive enable", oe[n], m_oc[n]);
            if (m_oc[n]) chk("R5 pin value", pin[n], lvl[n]);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk); we = 1'b1; ad = a; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int mx;
      void'($urandom(32'd20240611));
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", cnt, 0);
      chk("R1 run", run, 0);
      chk("R1 drive enables", oe, 2'b00);
      chk("R1 levels", lvl, 2'b00);

      // R7 start, R4 duty, R3 period A
      wr(3'd4, 16'd5); wr(3'd5, 16'd2); wr(3'd2, 16'd1); wr(3'd1, 16'd1);
      wr(3'd3, 16'd1);
      chk("R7 start from zero", cnt, 0);
      chk("R4 level high below duty", lvl[0], 1'b1);
      idle(2);
      chk("R4 level low at duty", lvl[0], 1'b0);
      idle(3);
      chk("R3 reached period A", cnt, 5);
      idle(1);
      chk("R3 wrap after A", cnt, 0);

      // R6 control write ignored while running (divider stays 1)
      wr(3'd0, 16'd3);
      mx = int'(cnt);
      idle(1);
      chk("R6 divider unchanged", cnt, (mx == 5) ? 0 : mx + 1);

      // R7 second start request while running ignored
      mx = int'(cnt);
      wr(3'd3, 16'd1);
      chk("R7 start while running no reset", cnt, (mx + 2) % 6);

      // R2 divider 16
      wr(3'd3, 16'd0);
      wr(3'd0, 16'd2); wr(3'd4, 16'd3);
      wr(3'd3, 16'd1);
      idle(15);
      chk("R2 held for 16 clocks", cnt, 0);
      idle(1);
      chk("R2 tick after 16 clocks", cnt, 1);

      // R8 mid-period period change below current count
      wr(3'd3, 16'd0);
      wr(3'd0, 16'd0); wr(3'd4, 16'd10);
      wr(3'd3, 16'd1);
      idle(4);
      wr(3'd4, 16'd3);
      mx = 0;
      for (int i = 0; i < 40 && cnt != 0; i++) begin
         if (int'(cnt) > mx) mx = int'(cnt);
         idle(1);
      end
      chk("R8 old period completes", mx, 10);
      mx = 0;
      idle(1);
      for (int i = 0; i < 40 && cnt != 0; i++) begin
         if (int'(cnt) > mx) mx = int'(cnt);
         idle(1);
      end
      chk("R8 new period used", mx, 3);

      // R9 mode off forces low
      wr(3'd5, 16'd3); idle(5);
      wr(3'd1, 16'd0);
      chk("R9 mode off levels", lvl, 2'b00);
      wr(3'd1, 16'd1);

      // R5 Hi-Z control
      wr(3'd2, 16'd0);
      chk("R5 both released", oe, 2'b00);
      wr(3'd2, 16'd2);
      chk("R5 only output 1 driven", oe, 2'b10);

      // R3 clear source C
      wr(3'd3, 16'd0);
      wr(3'd0, 16'd4); wr(3'd6, 16'd4); wr(3'd4, 16'd100); wr(3'd7, 16'd2);
      wr(3'd3, 16'd1);
      idle(4);
      chk("R3 reached period C", cnt, 4);
      idle(1);
      chk("R3 wrap after C", cnt, 0);
      chk("R4 output 1 high below D", lvl[1], 1'b1);

      // R7 stop freezes count
      idle(2);
      wr(3'd3, 16'd0);
      mx = int'(cnt);
      idle(3);
      chk("R7 count frozen when stopped", cnt, mx);

      // constrained random phase, checked by the cycle model each clock
      for (int k = 0; k < 3000; k++) begin
         int unsigned r;
         r = $urandom % 16;
         if (r < 6) begin
            logic [W-1:0] v;
            v = ($urandom % 10 == 0) ? 16'hFFFF : W'($urandom % 24);
            wr(3'd4 + 3'($urandom % 4), v);
         end else if (r < 8) begin
            logic [1:0] c;
            c = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
            wr(3'd0, {13'd0, 1'($urandom % 2), c});
         end else if (r < 10) begin
            wr(3'd3, W'($urandom % 4 != 0));
         end else if (r == 10) begin
            wr(3'd1, W'($urandom % 4 != 0));
         end else if (r == 11) begin
            wr(3'd2, W'($urandom % 4));
         end else begin
            idle(1 + int'($urandom % 8));
         end
      end
      idle(2);
      finish_run();
   end
endmodule